// File: doc/BRIEF.md
# Macro-Expanding Instruction Decoder

This block sits between instruction fetch and the execution core. It takes one 64-bit instruction word at a time, together with the address it was fetched from, and turns it into a stream of simple micro-operations. An ordinary instruction leaves as exactly one micro-operation, bit for bit the same as the fetched word. A macro-instruction is unrolled in hardware into a run of ordinary micro-operations. The execution core cannot tell that run apart from the same sequence written out by hand.

The macro built here is a multi-register clear. It names a first and a last register and produces one "XOR a register with itself" micro-operation for each register in that inclusive range, in ascending order. While a run is being produced, the decoder holds fetch off by keeping its input ready signal low. Both streams use valid/ready handshakes. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge, and a micro-operation is delivered when `out_valid` and `out_ready` are both high. Once `out_valid` is raised, the decoder keeps it and `out_uop` unchanged until the consumer takes the micro-operation, so back-pressure never loses or reorders work. A misaligned fetch address or an unassigned opcode raises a one-cycle fault pulse and issues nothing. A synchronous flush drops any run in progress.

Top module: `macro_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and both fault outputs are 0.
- R2: A word with an opcode in bits [63:56] from 0x00 to 0x07 is issued as exactly one micro-operation equal to the input word.
- R3: A word with opcode 0x40 takes its first register from bits [55:52] and its last register from bits [51:48]. It issues one micro-operation per register r from first to last, in ascending order. Each has opcode 0x05 in [63:56], r in each of [55:52], [51:48] and [47:44], and zeros in [43:0].
- R4: When the first register of a 0x40 word equals its last register, exactly one micro-operation is issued.
- R5: When the first register of a 0x40 word is greater than its last register, no micro-operation and no fault is produced.
- R6: An accepted word whose address has any of bits [2:0] set raises `fault_misalign` for one cycle on the edge after acceptance and issues nothing. The alignment check is made before the opcode check.
- R7: An aligned word whose opcode is neither 0x00 to 0x07 nor 0x40 raises `fault_illegal` for one cycle on the edge after acceptance and issues nothing.
- R8: `in_ready` stays 0 from the edge that accepts a multi-register 0x40 word until its last micro-operation has been loaded on the output.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_uop` keeps its value. The expansion does not advance, so no micro-operation is lost under any pattern of back-pressure.
- R10: On the edge after `flush` is high, `out_valid` is 0 and `in_ready` is 1. The rest of any run is dropped, and a word presented during the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous abort of the current expansion and output |
| in_valid | input | 1 | Fetch offers a word |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 64 | Fetched instruction word |
| in_addr | input | ADDR_W | Fetch address of the word |
| out_valid | output | 1 | A micro-operation is on `out_uop` |
| out_ready | input | 1 | Execution core takes the micro-operation |
| out_uop | output | 64 | Micro-operation word |
| fault_misalign | output | 1 | One-cycle pulse for a misaligned fetch |
| fault_illegal | output | 1 | One-cycle pulse for an unassigned opcode |

## Verification
The in-line assertions check, on every cycle, that a stalled output holds still, that a fault pulse never comes with a valid output, that the two faults never fire together, that fetch is held off right after a multi-register clear is accepted, and that a flush leaves the output empty and ready. Only the bench's scenarios can show the content and order of the expanded runs. The same holds for the exact count of micro-operations for a full, single and inverted range, for pass-through equality, and for a run that stays complete and in order while the consumer stalls irregularly.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
  localparam int WORD_W = 64;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 4;
  localparam int OPC_LO = WORD_W - OPC_W;
  localparam int RA_LO  = OPC_LO - REG_W;
  localparam int RB_LO  = RA_LO - REG_W;
  localparam int RC_LO  = RB_LO - REG_W;

  localparam logic [OPC_W-1:0] OP_PASS_MAX = 8'h07;
  localparam logic [OPC_W-1:0] OP_XOR      = 8'h05;
  localparam logic [OPC_W-1:0] OP_CLRRANGE = 8'h40;

  typedef enum logic [1:0] {
    KIND_PASS    = 2'd0,
    KIND_MACRO   = 2'd1,
    KIND_ILLEGAL = 2'd2
  } kind_e;

  function automatic logic [WORD_W-1:0] self_xor(input logic [REG_W-1:0] r);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:OPC_LO] = OP_XOR;
    w[OPC_LO-1:RA_LO]  = r;
    w[RA_LO-1:RB_LO]   = r;
    w[RB_LO-1:RC_LO]   = r;
    return w;
  endfunction
endpackage

// File: rtl/mxd_align_check.sv
module mxd_align_check #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  generate
    if (ALIGN_BITS > 0) begin : g_chk
      assign misaligned = |addr[ALIGN_BITS-1:0];
    end else begin : g_none
      assign misaligned = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mxd_opcode_classify.sv
module mxd_opcode_classify
  import mxd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output kind_e            kind
);
  always_comb begin
    if (opcode <= OP_PASS_MAX)      kind = KIND_PASS;
    else if (opcode == OP_CLRRANGE) kind = KIND_MACRO;
    else                            kind = KIND_ILLEGAL;
  end
endmodule

// File: rtl/mxd_expand_seq.sv
module mxd_expand_seq
  import mxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  logic              misaligned,
  input  kind_e             kind,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_uop,
  output logic              busy,
  output logic              fault_misalign,
  output logic              fault_illegal
);
  logic [REG_W-1:0] first_r, last_r;
  logic [REG_W-1:0] cur_q, last_q;
  logic             advance;

  assign first_r = word[OPC_LO-1:RA_LO];
  assign last_r  = word[RA_LO-1:RB_LO];
  assign advance = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_uop        <= '0;
      busy           <= 1'b0;
      cur_q          <= '0;
      last_q         <= '0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
    end else if (flush) begin
      out_valid      <= 1'b0;
      busy           <= 1'b0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
    end else begin
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
      if (busy) begin
        if (advance) begin
          out_valid <= 1'b1;
          out_uop   <= self_xor(cur_q);
          if (cur_q == last_q) busy <= 1'b0;
          else                 cur_q <= cur_q + 1'b1;
        end
      end else if (accept) begin
        if (misaligned) begin
          fault_misalign <= 1'b1;
          out_valid      <= 1'b0;
        end else begin
          unique case (kind)
            KIND_PASS: begin
              out_valid <= 1'b1;
              out_uop   <= word;
            end
            KIND_MACRO: begin
              if (first_r > last_r) begin
                out_valid <= 1'b0;
              end else begin
                out_valid <= 1'b1;
                out_uop   <= self_xor(first_r);
                if (first_r != last_r) begin
                  busy   <= 1'b1;
                  cur_q  <= first_r + 1'b1;
                  last_q <= last_r;
                end
              end
            end
            default: begin
              fault_illegal <= 1'b1;
              out_valid     <= 1'b0;
            end
          endcase
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_uop)));

  // R8
  expand_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flush && !misaligned && kind == KIND_MACRO && first_r < last_r) |=> busy);

  // R6
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_misalign |-> !out_valid);

  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_illegal |-> (!out_valid && !fault_misalign));
endmodule

// File: rtl/macro_decoder.sv
module macro_decoder
  import mxd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_uop,
  output logic              fault_misalign,
  output logic              fault_illegal
);
  logic  misaligned;
  kind_e kind;
  logic  busy;
  logic  accept;

  assign in_ready = !busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready && !flush;

  mxd_align_check #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .addr       (in_addr),
    .misaligned (misaligned)
  );

  mxd_opcode_classify u_class (
    .opcode (in_word[WORD_W-1:OPC_LO]),
    .kind   (kind)
  );

  mxd_expand_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .accept         (accept),
    .word           (in_word),
    .misaligned     (misaligned),
    .kind           (kind),
    .out_ready      (out_ready),
    .out_valid      (out_valid),
    .out_uop        (out_uop),
    .busy           (busy),
    .fault_misalign (fault_misalign),
    .fault_illegal  (fault_illegal)
  );

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready));
endmodule

// File: tb/sim_macro_decoder.sv
`timescale 1ns/1ps
module sim_macro_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_uop;
  logic        fault_misalign;
  logic        fault_illegal;

  int checks = 0;
  int errors = 0;
  logic [63:0] log_q [0:63];
  int n_uop = 0;
  int n_mis = 0;
  int n_ill = 0;
  bit bp_en = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  macro_decoder u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_uop(out_uop),
    .fault_misalign(fault_misalign), .fault_illegal(fault_illegal)
  );

  always @(negedge clk) begin
    cyc++;
    if (bp_en) out_ready = (cyc % 3) != 0;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (n_uop < 64) log_q[n_uop] = out_uop;
        n_uop++;
      end
      if (fault_misalign) n_mis++;
      if (fault_illegal)  n_ill++;
    end
  end

  function automatic logic [63:0] xor_op(input int r);
    logic [3:0] q;
    q = r[3:0];
    return {8'h05, q, q, q, 44'h0};
  endfunction

  function automatic logic [63:0] clr_word(input int f, input int l);
    logic [3:0] a, b;
    a = f[3:0];
    b = l[3:0];
    return {8'h40, a, b, 48'h1234_5678_9abc};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_uop = 0; n_mis = 0; n_ill = 0;
  endtask

  task automatic send(input logic [63:0] w, input logic [31:0] a);
    @(negedge clk);
    in_word = w; in_addr = a; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic check_run(input string tag, input int f, input int l);
    int exp_n;
    exp_n = (f > l) ? 0 : (l - f + 1);
    check(n_uop == exp_n, tag, 64'(n_uop), 64'(exp_n));
    for (int i = 0; i < exp_n && i < n_uop; i++)
      check(log_q[i] == xor_op(f + i), tag, log_q[i], xor_op(f + i));
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    check(fault_misalign == 1'b0 && fault_illegal == 1'b0, "R1 faults",
          64'({fault_misalign, fault_illegal}), 64'd0);
  endtask

  task automatic t_pass();
    clear_log();
    send(64'h0100_1122_3344_5566, 32'h100);
    send(64'h0700_ffee_ddcc_bbaa, 32'h108);
    idle(4);
    check(n_uop == 2, "R2 count", 64'(n_uop), 64'd2);
    check(log_q[0] == 64'h0100_1122_3344_5566, "R2 first", log_q[0], 64'h0100_1122_3344_5566);
    check(log_q[1] == 64'h0700_ffee_ddcc_bbaa, "R2 second", log_q[1], 64'h0700_ffee_ddcc_bbaa);
  endtask

  task automatic t_full_range();
    clear_log();
    send(clr_word(1, 15), 32'h200);
    idle(24);
    check_run("R3 range 1..15", 1, 15);
  endtask

  task automatic t_single();
    clear_log();
    send(clr_word(5, 5), 32'h208);
    idle(6);
    check_run("R4 range 5..5", 5, 5);
  endtask

  task automatic t_inverted();
    clear_log();
    send(clr_word(9, 3), 32'h210);
    idle(6);
    check(n_uop == 0, "R5 count", 64'(n_uop), 64'd0);
    check(n_mis == 0 && n_ill == 0, "R5 no fault", 64'(n_mis + n_ill), 64'd0);
  endtask

  task automatic t_misalign();
    clear_log();
    send(64'h0300_0000_0000_0001, 32'h204);
    idle(4);
    check(n_uop == 0, "R6 nothing issued", 64'(n_uop), 64'd0);
    check(n_mis == 1, "R6 pulse", 64'(n_mis), 64'd1);
    clear_log();
    send(64'hEE00_0000_0000_0000, 32'h301);
    idle(4);
    check(n_mis == 1 && n_ill == 0, "R6 before opcode", 64'({n_mis[3:0], n_ill[3:0]}), 64'h10);
  endtask

  task automatic t_illegal();
    clear_log();
    send(64'hEE00_0000_0000_0000, 32'h300);
    idle(4);
    check(n_uop == 0, "R7 nothing issued", 64'(n_uop), 64'd0);
    check(n_ill == 1, "R7 pulse", 64'(n_ill), 64'd1);
  endtask

  task automatic t_backpressure();
    clear_log();
    bp_en = 1'b1;
    send(clr_word(0, 15), 32'h400);
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R8 fetch held", 64'(in_ready), 64'd0);
    idle(70);
    bp_en = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    idle(2);
    check_run("R9 stalled range 0..15", 0, 15);
    check(in_ready == 1'b1, "R8 released", 64'(in_ready), 64'd1);
  endtask

  task automatic t_flush();
    clear_log();
    out_ready = 1'b1;
    send(clr_word(0, 15), 32'h500);
    repeat (3) @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
    idle(20);
    check(n_uop > 0 && n_uop < 16, "R10 run cut", 64'(n_uop), 64'd4);
    for (int i = 0; i < n_uop && i < 16; i++)
      check(log_q[i] == xor_op(i), "R10 order", log_q[i], xor_op(i));
    clear_log();
    send(64'h0200_0000_0000_00aa, 32'h508);
    idle(4);
    check(n_uop == 1 && log_q[0] == 64'h0200_0000_0000_00aa, "R10 resume", log_q[0], 64'h0200_0000_0000_00aa);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_pass();
    t_full_range();
    t_single();
    t_inverted();
    t_misalign();
    t_illegal();
    t_backpressure();
    t_flush();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule